// File: doc/BRIEF.md
# Double-Buffered BCD Clock Calendar

This block keeps the time of day and the calendar date in packed BCD: century, year, month, day of month, day of week, hours on a 24-hour dial, minutes and seconds. A free-running prescaler counts a 32.768 kHz clock-enable input. It produces one timing pulse per second, and that pulse advances a set of running counters. The counters correct month lengths and February 29 without help from the host.

A host reaches the block through a byte-wide register window. The window has a chip select, read and write strobes, an address and separate write and read data buses. The host never touches the running counters directly. It sees a second copy of them, the external copy, which follows the counters once per second. Two control bits freeze that copy. The read-halt bit holds it still so that a multi-byte read is coherent. The write-halt bit also holds it still, and when the host clears the write-halt bit the values it wrote into the copy are committed to the running counters. An oscillator-stop bit in the seconds register halts all timekeeping. That bit is set at reset.

Top module: `bcd_timekeeper`

## Requirements
- R1: After reset the eight registers read as follows. Offset 0 (control) reads 0x20, offset 1 (seconds) reads 0x80, offsets 2 and 3 (minutes, hours) read 0x00, and offsets 4 to 7 (day of week, date, month, year) read 0x01, 0x01, 0x01 and 0x00. The registers occupy the top eight addresses of the window (0x1FF8 to 0x1FFF). Control is bit 7 = write-halt W, bit 6 = read-halt R, bits 5:0 = century.
- R2: Bits outside each field's width read as 0. The field widths are seconds 7 bits, minutes 7, hours 6, day 3, date 6, month 5, year 8 and century 6. An address below 0x1FF8 reads 0x00, and a write to such an address changes no register.
- R3: While W or R is 1, the once-per-second update does not change the external copy.
- R4: A control write that sets R from 0, with W at 0, captures the running count into the external copy. After R is cleared, the copy shows the running count again from the next seconds pulse onward.
- R5: A control write that clears W while W is 1 loads every written time field into the running counters, taking the century from that same write. Counting then continues from the loaded values.
- R6: Seconds bit 7 is the oscillator stop. At 1, the prescaler is held at zero and the time does not change. At 0, every 2^PRESC_W enable pulses make one seconds pulse.
- R7: Seconds wrap from 59 to 00 and carry into minutes, minutes wrap from 59 and carry into hours, and hours wrap from 23 and carry into the date.
- R8: Day of week counts 1 to 7 and wraps from 7 to 1 whenever the date advances.
- R9: April, June, September and November end on day 30. The other months except February end on day 31. Month 12 wraps to 01 and carries into the year.
- R10: February ends on day 29 when the year value is divisible by 4 (00 included), and on day 28 otherwise.
- R11: Year 99 wraps to 00 and carries into the century, and century 39 wraps to 00.
- R12: A write to a time register while W is 0 changes only the external copy, and the next seconds pulse overwrites it.
- R13: When a commit and a seconds pulse fall in the same cycle, the commit wins. The counters hold the committed values and advance only on the following pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xtal_en | input | 1 | Single-cycle enable at the 32.768 kHz rate |
| cs | input | 1 | Chip select |
| rd | input | 1 | Read strobe; rdata is combinational while cs and rd are high |
| wr | input | 1 | Write strobe; the write takes effect at the clock edge |
| addr | input | ADDR_W | Byte address in the window |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data; 0x00 when no read to the register area is active |

## Verification
A host commit, which clears the write-halt bit, can land in the same cycle as the prescaler's seconds pulse. The two then compete to load the running counters. The bench drives the enable input by hand, so it knows the exact cycle in which the prescaler wraps. It issues the control write in the cycle of the eighth enable. It then reads the seconds field before and after one further second. A commit that lost would show as an advance of one or of two, and a correct commit shows the written value and then that value plus one. The freeze and commit paths are also checked across whole seconds in which the running count moves while the external copy does not.

// File: rtl/tk_pkg.sv
`timescale 1ns/1ps
package tk_pkg;

  typedef struct packed {
    logic [7:0] cen;
    logic [7:0] yr;
    logic [7:0] mon;
    logic [7:0] date;
    logic [7:0] day;
    logic [7:0] hrs;
    logic [7:0] mins;
    logic [7:0] secs;
  } tk_time_t;

  localparam tk_time_t TK_RESET_TIME = '{cen: 8'h20, yr: 8'h00, mon: 8'h01,
                                         date: 8'h01, day: 8'h01, hrs: 8'h00,
                                         mins: 8'h00, secs: 8'h00};

  // register offsets inside the top eight addresses
  localparam logic [2:0] OFF_CTRL = 3'd0;
  localparam logic [2:0] OFF_SEC  = 3'd1;
  localparam logic [2:0] OFF_MIN  = 3'd2;
  localparam logic [2:0] OFF_HR   = 3'd3;
  localparam logic [2:0] OFF_DAY  = 3'd4;
  localparam logic [2:0] OFF_DATE = 3'd5;
  localparam logic [2:0] OFF_MON  = 3'd6;
  localparam logic [2:0] OFF_YR   = 3'd7;

  // one BCD step; anything at or past the top (including junk) wraps to first
  function automatic logic [7:0] bcd_next(input logic [7:0] v,
                                          input logic [7:0] top,
                                          input logic [7:0] first);
    if (v >= top)            return first;
    else if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                     return v + 8'd1;
  endfunction

  function automatic logic bcd_leap(input logic [7:0] yr);
    if (!yr[4]) return (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
    else        return (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
  endfunction

  function automatic logic [7:0] month_last(input logic [7:0] mon, input logic [7:0] yr);
    case (mon)
      8'h02:                      return bcd_leap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/tk_prescaler.sv
`timescale 1ns/1ps
module tk_prescaler #(
  parameter int PRESC_W = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stop,
  input  logic en,
  output logic tick
);
  localparam logic [PRESC_W-1:0] LAST = '1;

  logic [PRESC_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (stop)  cnt_q <= '0;
    else if (en)    cnt_q <= cnt_q + 1'b1;
  end

  assign tick = en && !stop && (cnt_q == LAST);
endmodule

// File: rtl/tk_calendar_step.sv
`timescale 1ns/1ps
module tk_calendar_step
  import tk_pkg::*;
(
  input  tk_time_t cur,
  output tk_time_t nxt
);
  logic       c_min, c_hr, c_date, c_mon, c_yr, c_cen;
  logic [7:0] last_day;

  always_comb begin
    last_day = month_last(cur.mon, cur.yr);
    c_min    = (cur.secs >= 8'h59);
    c_hr     = c_min  && (cur.mins >= 8'h59);
    c_date   = c_hr   && (cur.hrs  >= 8'h23);
    c_mon    = c_date && (cur.date >= last_day);
    c_yr     = c_mon  && (cur.mon  >= 8'h12);
    c_cen    = c_yr   && (cur.yr   >= 8'h99);

    nxt      = cur;
    nxt.secs = bcd_next(cur.secs, 8'h59, 8'h00);
    if (c_min)  nxt.mins = bcd_next(cur.mins, 8'h59, 8'h00);
    if (c_hr)   nxt.hrs  = bcd_next(cur.hrs,  8'h23, 8'h00);
    if (c_date) begin
      nxt.day  = bcd_next(cur.day,  8'h07,    8'h01);
      nxt.date = bcd_next(cur.date, last_day, 8'h01);
    end
    if (c_mon)  nxt.mon  = bcd_next(cur.mon, 8'h12, 8'h01);
    if (c_yr)   nxt.yr   = bcd_next(cur.yr,  8'h99, 8'h00);
    if (c_cen)  nxt.cen  = bcd_next(cur.cen, 8'h39, 8'h00);
  end
endmodule

// File: rtl/tk_core.sv
`timescale 1ns/1ps
module tk_core
  import tk_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick,
  input  logic     load,
  input  tk_time_t load_val,
  output tk_time_t cur,
  output tk_time_t cur_d
);
  tk_time_t cur_q, stepped;

  tk_calendar_step u_step (.cur(cur_q), .nxt(stepped));

  // a commit outranks the seconds pulse
  always_comb begin
    if (load)      cur_d = load_val;
    else if (tick) cur_d = stepped;
    else           cur_d = cur_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_q <= TK_RESET_TIME;
    else        cur_q <= cur_d;
  end

  assign cur = cur_q;
endmodule

// File: rtl/bcd_timekeeper.sv
`timescale 1ns/1ps
module bcd_timekeeper
  import tk_pkg::*;
#(
  parameter int ADDR_W  = 13,
  parameter int PRESC_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xtal_en,
  input  logic              cs,
  input  logic              rd,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata
);
  localparam int OFF_W = 3;

  logic [OFF_W-1:0] off;
  logic             in_win, wr_hit, rd_hit, ctrl_wr;
  logic             w_bit, r_bit, osc_stop, halt;
  logic             sec_tick, commit, capture, ext_follow;
  tk_time_t         ext_q, int_q, int_d, commit_val;

  assign off     = addr[OFF_W-1:0];
  assign in_win  = &addr[ADDR_W-1:OFF_W];
  assign wr_hit  = cs && wr && in_win;
  assign rd_hit  = cs && rd && in_win;
  assign ctrl_wr = wr_hit && (off == OFF_CTRL);
  assign halt    = w_bit || r_bit;

  assign commit     = ctrl_wr && w_bit && !wdata[7];
  assign capture    = ctrl_wr && !w_bit && !r_bit && wdata[6] && !wdata[7];
  assign ext_follow = sec_tick && !halt;

  always_comb begin
    commit_val     = ext_q;
    commit_val.cen = {2'b00, wdata[5:0]};
  end

  tk_prescaler #(.PRESC_W(PRESC_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .stop(osc_stop), .en(xtal_en), .tick(sec_tick)
  );

  tk_core u_core (
    .clk(clk), .rst_n(rst_n), .tick(sec_tick), .load(commit),
    .load_val(commit_val), .cur(int_q), .cur_d(int_d)
  );

  // control bits and oscillator stop
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_bit    <= 1'b0;
      r_bit    <= 1'b0;
      osc_stop <= 1'b1;
    end else begin
      if (ctrl_wr) begin
        w_bit <= wdata[7];
        r_bit <= wdata[6];
      end
      if (wr_hit && off == OFF_SEC) osc_stop <= wdata[7];
    end
  end

  // external copy: follows the counters once per second unless halted
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_q <= TK_RESET_TIME;
    end else begin
      if (capture || ext_follow) ext_q <= int_d;
      if (wr_hit && !capture) begin
        case (off)
          OFF_CTRL: ext_q.cen  <= {2'b00, wdata[5:0]};
          OFF_SEC:  ext_q.secs <= {1'b0, wdata[6:0]};
          OFF_MIN:  ext_q.mins <= {1'b0, wdata[6:0]};
          OFF_HR:   ext_q.hrs  <= {2'b00, wdata[5:0]};
          OFF_DAY:  ext_q.day  <= {5'b00000, wdata[2:0]};
          OFF_DATE: ext_q.date <= {2'b00, wdata[5:0]};
          OFF_MON:  ext_q.mon  <= {3'b000, wdata[4:0]};
          default:  ext_q.yr   <= wdata;
        endcase
      end
    end
  end

  always_comb begin
    rdata = 8'h00;
    if (rd_hit) begin
      case (off)
        OFF_CTRL: rdata = {w_bit, r_bit, ext_q.cen[5:0]};
        OFF_SEC:  rdata = {osc_stop, ext_q.secs[6:0]};
        OFF_MIN:  rdata = ext_q.mins;
        OFF_HR:   rdata = ext_q.hrs;
        OFF_DAY:  rdata = ext_q.day;
        OFF_DATE: rdata = ext_q.date;
        OFF_MON:  rdata = ext_q.mon;
        default:  rdata = ext_q.yr;
      endcase
    end
  end
endmodule

// File: rtl/tk_checker.sv
`timescale 1ns/1ps
module tk_checker
  import tk_pkg::*;
(
  input logic     clk,
  input logic     rst_n,
  input logic     tick,
  input logic     commit,
  input logic     halt,
  input logic     host_wr,
  input logic     osc_stop,
  input tk_time_t ext_t,
  input tk_time_t int_t
);
  AST_EXT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    halt && !host_wr |=> $stable(ext_t));                               // R3

  AST_EXT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !halt && !host_wr |=> ext_t == int_t);                      // R4

  AST_COMMIT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> int_t.secs == $past(ext_t.secs) && int_t.mins == $past(ext_t.mins)
               && int_t.hrs == $past(ext_t.hrs) && int_t.date == $past(ext_t.date)); // R5

  AST_COMMIT_BEATS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    commit && tick |=> int_t.secs == $past(ext_t.secs));                // R13

  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    osc_stop && !commit |=> $stable(int_t));                            // R6

  AST_TICK_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !commit |=> int_t.secs != $past(int_t.secs));               // R7
endmodule

bind bcd_timekeeper tk_checker u_chk (
  .clk(clk), .rst_n(rst_n), .tick(sec_tick), .commit(commit), .halt(halt),
  .host_wr(wr_hit), .osc_stop(osc_stop), .ext_t(ext_q), .int_t(int_q)
);

// File: tb/sim_bcd_timekeeper.sv
`timescale 1ns/1ps
module sim_bcd_timekeeper;
  localparam int PW = 3;
  localparam int TICKS = 1 << PW;

  localparam logic [12:0] A_CTRL = 13'h1FF8, A_SEC = 13'h1FF9, A_MIN = 13'h1FFA,
                          A_HR = 13'h1FFB, A_DAY = 13'h1FFC, A_DATE = 13'h1FFD,
                          A_MON = 13'h1FFE, A_YR = 13'h1FFF;

  logic clk = 1'b0, rst_n = 1'b0, xtal_en = 1'b0, cs = 1'b0, rd_s = 1'b0, wr_s = 1'b0;
  logic [12:0] addr = '0;
  logic [7:0]  wdata = '0, rdata;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  bcd_timekeeper #(.ADDR_W(13), .PRESC_W(PW)) u0 (
    .clk(clk), .rst_n(rst_n), .xtal_en(xtal_en), .cs(cs), .rd(rd_s), .wr(wr_s),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [12:0] a, input logic [7:0] d);
    @(negedge clk); cs = 1; wr_s = 1; addr = a; wdata = d;
    @(negedge clk); cs = 0; wr_s = 0;
  endtask

  task automatic bus_rd(input logic [12:0] a, output logic [7:0] d);
    @(negedge clk); cs = 1; rd_s = 1; addr = a;
    #1 d = rdata;
    cs = 0; rd_s = 0;
  endtask

  task automatic expect_reg(input string tag, input logic [12:0] a, input logic [7:0] exp);
    logic [7:0] v;
    bus_rd(a, v);
    check(tag, v, exp);
  endtask

  task automatic seconds(input int n);
    @(negedge clk); xtal_en = 1;
    repeat (n * TICKS) @(negedge clk);
    xtal_en = 0;
  endtask

  task automatic set_time(input logic [7:0] cen, yr, mon, date, day, hr, mn, sc);
    bus_wr(A_CTRL, {2'b10, cen[5:0]});
    bus_wr(A_SEC, sc); bus_wr(A_MIN, mn); bus_wr(A_HR, hr); bus_wr(A_DAY, day);
    bus_wr(A_DATE, date); bus_wr(A_MON, mon); bus_wr(A_YR, yr);
    bus_wr(A_CTRL, {2'b00, cen[5:0]});
  endtask

  task automatic expect_date(input string tag, input logic [7:0] cen, yr, mon, date, day);
    expect_reg(tag, A_CTRL, cen); expect_reg(tag, A_YR, yr);
    expect_reg(tag, A_MON, mon); expect_reg(tag, A_DATE, date);
    expect_reg(tag, A_DAY, day);
  endtask

  task automatic t_reset;
    expect_reg("R1 ctrl", A_CTRL, 8'h20); expect_reg("R1 sec", A_SEC, 8'h80);
    expect_reg("R1 min", A_MIN, 8'h00);   expect_reg("R1 hr", A_HR, 8'h00);
    expect_reg("R1 day", A_DAY, 8'h01);   expect_reg("R1 date", A_DATE, 8'h01);
    expect_reg("R1 mon", A_MON, 8'h01);   expect_reg("R1 yr", A_YR, 8'h00);
  endtask

  task automatic t_stopped;
    seconds(2);
    expect_reg("R6 stopped sec", A_SEC, 8'h80);
    expect_reg("R6 stopped min", A_MIN, 8'h00);
  endtask

  task automatic t_masks;
    bus_wr(A_CTRL, 8'hA0);
    bus_wr(A_HR, 8'hFF); expect_reg("R2 hr mask", A_HR, 8'h3F);
    bus_wr(A_DAY, 8'hFF); expect_reg("R2 day mask", A_DAY, 8'h07);
    bus_wr(A_MON, 8'hFF); expect_reg("R2 mon mask", A_MON, 8'h1F);
    bus_wr(13'h1FF0, 8'h55); expect_reg("R2 outside read", 13'h1FF0, 8'h00);
    expect_reg("R2 outside write no effect", A_YR, 8'h00);
    bus_wr(A_CTRL, 8'h20);
  endtask

  task automatic t_rollover;
    set_time(8'h20, 8'h23, 8'h12, 8'h31, 8'h07, 8'h23, 8'h59, 8'h58);
    seconds(1);
    expect_reg("R7 sec 58->59", A_SEC, 8'h59);
    seconds(1);
    expect_reg("R7 sec wrap", A_SEC, 8'h00);
    expect_reg("R7 min wrap", A_MIN, 8'h00);
    expect_reg("R7 hr wrap", A_HR, 8'h00);
    expect_date("R8 R9 new year", 8'h20, 8'h24, 8'h01, 8'h01, 8'h01);
    set_time(8'h20, 8'h99, 8'h12, 8'h31, 8'h03, 8'h23, 8'h59, 8'h59);
    seconds(1);
    expect_date("R11 century carry", 8'h21, 8'h00, 8'h01, 8'h01, 8'h04);
    set_time(8'h39, 8'h99, 8'h12, 8'h31, 8'h03, 8'h23, 8'h59, 8'h59);
    seconds(1);
    expect_reg("R11 century wrap", A_CTRL, 8'h00);
  endtask

  task automatic t_months;
    set_time(8'h20, 8'h23, 8'h04, 8'h30, 8'h02, 8'h23, 8'h59, 8'h59);
    seconds(1); expect_date("R9 april end", 8'h20, 8'h23, 8'h05, 8'h01, 8'h03);
    set_time(8'h20, 8'h23, 8'h05, 8'h30, 8'h02, 8'h23, 8'h59, 8'h59);
    seconds(1); expect_reg("R9 may 31", A_DATE, 8'h31);
    set_time(8'h20, 8'h23, 8'h02, 8'h28, 8'h02, 8'h23, 8'h59, 8'h59);
    seconds(1); expect_date("R10 feb common", 8'h20, 8'h23, 8'h03, 8'h01, 8'h03);
    set_time(8'h20, 8'h24, 8'h02, 8'h28, 8'h02, 8'h23, 8'h59, 8'h59);
    seconds(1); expect_date("R10 feb leap 29", 8'h20, 8'h24, 8'h02, 8'h29, 8'h03);
    set_time(8'h20, 8'h24, 8'h02, 8'h29, 8'h02, 8'h23, 8'h59, 8'h59);
    seconds(1); expect_date("R10 leap feb end", 8'h20, 8'h24, 8'h03, 8'h01, 8'h03);
    set_time(8'h20, 8'h00, 8'h02, 8'h28, 8'h02, 8'h23, 8'h59, 8'h59);
    seconds(1); expect_reg("R10 year 00 leap", A_DATE, 8'h29);
  endtask

  task automatic t_freeze;
    set_time(8'h20, 8'h25, 8'h06, 8'h10, 8'h02, 8'h12, 8'h00, 8'h00);
    bus_wr(A_CTRL, 8'h60);
    expect_reg("R4 capture", A_SEC, 8'h00);
    seconds(2);
    expect_reg("R3 frozen by read bit", A_SEC, 8'h00);
    bus_wr(A_CTRL, 8'h20);
    expect_reg("R4 still old before pulse", A_SEC, 8'h00);
    seconds(1);
    expect_reg("R4 resumes", A_SEC, 8'h03);
  endtask

  task automatic t_shadow_write;
    set_time(8'h20, 8'h25, 8'h06, 8'h10, 8'h02, 8'h12, 8'h10, 8'h00);
    bus_wr(A_MIN, 8'h33);
    expect_reg("R12 copy holds host value", A_MIN, 8'h33);
    seconds(1);
    expect_reg("R12 overwritten", A_MIN, 8'h10);
    expect_reg("R12 sec advanced", A_SEC, 8'h01);
  endtask

  task automatic t_commit;
    set_time(8'h20, 8'h25, 8'h06, 8'h10, 8'h02, 8'h12, 8'h10, 8'h00);
    bus_wr(A_CTRL, 8'hA0);
    seconds(2);
    expect_reg("R3 frozen by write bit", A_SEC, 8'h00);
    bus_wr(A_SEC, 8'h10);
    bus_wr(A_CTRL, 8'h21);
    expect_reg("R5 century from commit", A_CTRL, 8'h21);
    seconds(1);
    expect_reg("R5 counts from commit", A_SEC, 8'h11);
    expect_reg("R5 min kept", A_MIN, 8'h10);
  endtask

  task automatic t_collide;
    set_time(8'h20, 8'h25, 8'h06, 8'h10, 8'h02, 8'h12, 8'h10, 8'h20);
    bus_wr(A_CTRL, 8'hA0);
    bus_wr(A_SEC, 8'h40);
    @(negedge clk); xtal_en = 1;
    repeat (TICKS - 1) @(negedge clk);
    cs = 1; wr_s = 1; addr = A_CTRL; wdata = 8'h20;
    @(negedge clk); cs = 0; wr_s = 0; xtal_en = 0;
    expect_reg("R13 commit wins", A_SEC, 8'h40);
    seconds(1);
    expect_reg("R13 next pulse advances", A_SEC, 8'h41);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_stopped();
    t_masks();
    t_rollover();
    t_months();
    t_freeze();
    t_shadow_write();
    t_commit();
    t_collide();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule